// File: doc/BRIEF.md
# Load/Store Address Generation and Lane Extension Unit

This unit sits between a register file and a data memory and serves loads and stores that use an immediate offset. For each request it builds the access address from a base value and an unsigned immediate. The immediate is added or subtracted under a direction flag. The unit then decides whether an updated base goes back to the register file. For stores it forms byte-lane strobes and lane-replicated write data. For loads it picks the addressed lane out of the returned memory word and widens it to a full register by zero or sign extension.

Three addressing modes are handled. In offset mode the base is left unchanged. In pre-indexed mode the access and the writeback both use the adjusted address. In post-indexed mode the access uses the raw base and the adjusted address is written back. A paired transfer moves two registers as two back-to-back word beats. Memory is assumed to answer reads combinationally in the same cycle, so the load result is valid alongside each beat. A request is accepted on a valid/ready handshake. A single transfer completes in the accept cycle. A paired transfer holds ready low for its second beat.

Top module: `ldst_addr_unit`

## Requirements
- R1: With mode_i = 2'b00 (offset; 2'b11 behaves the same), the access address is base_i plus or minus off_i, and wb_en_o stays low.
- R2: With mode_i = 2'b01 (pre-indexed), the access address and wb_data_o both equal the adjusted address, and wb_en_o is high in the accept cycle.
- R3: With mode_i = 2'b10 (post-indexed), the access address equals base_i, wb_data_o equals the adjusted address, and wb_en_o is high in the accept cycle.
- R4: sub_i = 1 subtracts off_i from base_i and sub_i = 0 adds it; off_i = 0 gives an access address equal to base_i.
- R5: Byte loads select lane addr[1:0] of mem_rdata_i. size_i = 3'b000 zero-extends it and size_i = 3'b001 sign-extends it from bit 7.
- R6: Halfword loads select the half given by addr[1]. size_i = 3'b010 zero-extends it and 3'b011 sign-extends it from bit 15. size_i = 3'b100 (word, also any code above 4) returns all 32 bits unchanged.
- R7: Stores drive acc_strb_o as follows. A byte store sets the single bit addr[1:0]. A halfword store sets 4'b0011 when addr[1] = 0 and 4'b1100 when addr[1] = 1. A word store sets 4'b1111. The store data is replicated into every lane of its width.
- R8: A store with a signed size (3'b001 or 3'b011) raises illegal_o in its access cycle and drives acc_strb_o to zero.
- R9: With pair_i = 1, beat 0 (acc_beat_o = 0) accesses the computed address with wdata_i. In the next cycle, beat 1 (acc_beat_o = 1) accesses that address plus 4 with wdata2_i. Both beats are word accesses.
- R10: During beat 1 of a paired transfer, req_ready_o is low and wb_en_o is low, so writeback happens once, in the accept cycle.
- R11: Out of reset req_ready_o is high and acc_valid_o is low. Outside beat 1, acc_valid_o follows req_valid_i, and each accepted single transfer completes in one cycle with ready still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| base_i | input | 32 | Base register value |
| off_i | input | 12 | Unsigned immediate magnitude |
| sub_i | input | 1 | 1 = subtract immediate |
| mode_i | input | 2 | Addressing mode |
| size_i | input | 3 | Access width and signedness |
| store_i | input | 1 | 1 = store, 0 = load |
| pair_i | input | 1 | Two-register transfer |
| wdata_i | input | 32 | Store data for the first register |
| wdata2_i | input | 32 | Store data for the second register |
| acc_valid_o | output | 1 | Memory access this cycle |
| acc_beat_o | output | 1 | 0 = first register, 1 = second |
| acc_addr_o | output | 32 | Memory byte address |
| acc_we_o | output | 1 | Access is a write |
| acc_strb_o | output | 4 | Byte-lane write strobes |
| acc_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Word returned by memory |
| ld_data_o | output | 32 | Extended load result |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | 32 | Base writeback value |
| illegal_o | output | 1 | Signed store attempted |

## Verification
The bench uses the default build: a 32-bit datapath and a 12-bit immediate. Four byte lanes give every byte position and both halfword positions, and the beat stride is 4. With a 12-bit immediate the bench can push base ± offset across a zero wrap and apply the largest offset (4095) in both directions. A small word memory in the bench answers reads and applies strobes. This lets paired stores be checked by reading back both words.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {AM_OFFSET = 2'd0, AM_PRE = 2'd1, AM_POST = 2'd2, AM_RSVD = 2'd3} amode_e;
  typedef enum logic [2:0] {
    SZ_UB = 3'd0, SZ_SB = 3'd1, SZ_UH = 3'd2, SZ_SH = 3'd3, SZ_W = 3'd4
  } asize_e;

  function automatic logic is_byte(logic [2:0] s);
    return s == SZ_UB || s == SZ_SB;
  endfunction

  function automatic logic is_half(logic [2:0] s);
    return s == SZ_UH || s == SZ_SH;
  endfunction

  function automatic logic is_signed(logic [2:0] s);
    return s == SZ_SB || s == SZ_SH;
  endfunction
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             sub_i,
  input  logic [1:0]       mode_i,
  output logic [XLEN-1:0]  addr_o,
  output logic             wb_en_o,
  output logic [XLEN-1:0]  wb_data_o
);
  import ldst_pkg::*;
  localparam int PAD = XLEN - OFF_W;

  logic [XLEN-1:0] off_ext, adj;

  assign off_ext = {{PAD{1'b0}}, off_i};
  assign adj     = sub_i ? base_i - off_ext : base_i + off_ext;

  always_comb begin
    wb_data_o = adj;
    unique case (amode_e'(mode_i))
      AM_PRE:  begin addr_o = adj;    wb_en_o = 1'b1; end
      AM_POST: begin addr_o = base_i; wb_en_o = 1'b1; end
      default: begin addr_o = adj;    wb_en_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ldst_lanes.sv
module ldst_lanes #(
  parameter int XLEN = 32
) (
  input  logic [$clog2(XLEN/8)-1:0] lane_i,
  input  logic [2:0]                size_i,
  input  logic                      store_i,
  input  logic [XLEN-1:0]           wdata_i,
  input  logic [XLEN-1:0]           rdata_i,
  output logic [XLEN/8-1:0]         strb_o,
  output logic [XLEN-1:0]           wdata_o,
  output logic [XLEN-1:0]           ldata_o,
  output logic                      illegal_o
);
  import ldst_pkg::*;
  localparam int NB  = XLEN / 8;
  localparam int LAW = $clog2(NB);

  logic            sz_b, sz_h, sz_s;
  logic [XLEN-1:0] byte_sh, half_sh;
  logic [7:0]      byte_v;
  logic [15:0]     half_v;
  logic [NB-1:0]   lane_hit;

  assign sz_b      = is_byte(size_i);
  assign sz_h      = is_half(size_i);
  assign sz_s      = is_signed(size_i);
  assign illegal_o = store_i && sz_s;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      if (sz_b)      lane_hit[i] = (LAW'(i) == lane_i);
      else if (sz_h) lane_hit[i] = ((LAW'(i) >> 1) == (lane_i >> 1));
      else           lane_hit[i] = 1'b1;
    end
  end

  assign strb_o = (store_i && !illegal_o) ? lane_hit : '0;

  always_comb begin
    if (sz_b)      wdata_o = {NB{wdata_i[7:0]}};
    else if (sz_h) wdata_o = {(NB/2){wdata_i[15:0]}};
    else           wdata_o = wdata_i;
  end

  // lane extraction, then extension
  assign byte_sh = rdata_i >> {lane_i, 3'b000};
  assign half_sh = rdata_i >> {lane_i[LAW-1:1], 4'b0000};
  assign byte_v  = byte_sh[7:0];
  assign half_v  = half_sh[15:0];

  always_comb begin
    if (sz_b)      ldata_o = {{(XLEN-8){sz_s & byte_v[7]}}, byte_v};
    else if (sz_h) ldata_o = {{(XLEN-16){sz_s & half_v[15]}}, half_v};
    else           ldata_o = rdata_i;
  end
endmodule

// File: rtl/ldst_beats.sv
module ldst_beats #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            pair_i,
  input  logic            store_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] wdata2_i,
  output logic            ready_o,
  output logic            accept_o,
  output logic            beat_o,
  output logic            store2_o,
  output logic [XLEN-1:0] addr2_o,
  output logic [XLEN-1:0] wdata2_o
);
  localparam int          NB     = XLEN / 8;
  localparam logic [XLEN-1:0] STRIDE = XLEN'(NB);

  logic busy_q;

  assign ready_o  = !busy_q;
  assign accept_o = valid_i && ready_o;
  assign beat_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      store2_o <= 1'b0;
      addr2_o  <= '0;
      wdata2_o <= '0;
    end else begin
      busy_q <= accept_o && pair_i;
      if (accept_o && pair_i) begin
        store2_o <= store_i;
        addr2_o  <= addr_i + STRIDE;
        wdata2_o <= wdata2_i;
      end
    end
  end

  assert_beat2_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && pair_i) |=> (!ready_o && beat_o));
  assert_beat2_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |=> !beat_o);
endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [XLEN-1:0]   base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              sub_i,
  input  logic [1:0]        mode_i,
  input  logic [2:0]        size_i,
  input  logic              store_i,
  input  logic              pair_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [XLEN-1:0]   wdata2_i,
  output logic              acc_valid_o,
  output logic              acc_beat_o,
  output logic [XLEN-1:0]   acc_addr_o,
  output logic              acc_we_o,
  output logic [XLEN/8-1:0] acc_strb_o,
  output logic [XLEN-1:0]   acc_wdata_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic [XLEN-1:0]   ld_data_o,
  output logic              wb_en_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              illegal_o
);
  import ldst_pkg::*;
  localparam int NB  = XLEN / 8;
  localparam int LAW = $clog2(NB);

  logic [XLEN-1:0] ag_addr, ag_wb, addr2, wdata2_q, lane_wd;
  logic            ag_wb_en, accept, beat, store2, lane_ill;
  logic [2:0]      eff_size;
  logic [NB-1:0]   lane_strb;

  ldst_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
    .base_i(base_i), .off_i(off_i), .sub_i(sub_i), .mode_i(mode_i),
    .addr_o(ag_addr), .wb_en_o(ag_wb_en), .wb_data_o(ag_wb)
  );

  ldst_beats #(.XLEN(XLEN)) u_beats (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(req_valid_i), .pair_i(pair_i),
    .store_i(store_i), .addr_i(ag_addr), .wdata2_i(wdata2_i),
    .ready_o(req_ready_o), .accept_o(accept), .beat_o(beat),
    .store2_o(store2), .addr2_o(addr2), .wdata2_o(wdata2_q)
  );

  assign acc_valid_o = accept || beat;
  assign acc_beat_o  = beat;
  assign acc_addr_o  = beat ? addr2 : ag_addr;
  assign acc_we_o    = acc_valid_o && (beat ? store2 : store_i);
  assign eff_size    = (beat || pair_i) ? 3'(SZ_W) : size_i;
  assign lane_wd     = beat ? wdata2_q : wdata_i;

  ldst_lanes #(.XLEN(XLEN)) u_lanes (
    .lane_i(acc_addr_o[LAW-1:0]), .size_i(eff_size), .store_i(acc_we_o),
    .wdata_i(lane_wd), .rdata_i(mem_rdata_i),
    .strb_o(lane_strb), .wdata_o(acc_wdata_o), .ldata_o(ld_data_o),
    .illegal_o(lane_ill)
  );

  assign acc_strb_o = lane_strb;
  assign illegal_o  = acc_valid_o && lane_ill;
  assign wb_en_o    = accept && ag_wb_en;
  assign wb_data_o  = ag_wb;

  assert_offset_no_wb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (mode_i == 2'd0 || mode_i == 2'd3)) |-> !wb_en_o);
  assert_post_raw_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_i == 2'd2) |-> (acc_addr_o == base_i && wb_en_o));
  assert_store_has_lanes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_o && !illegal_o) |-> (acc_strb_o != '0));
  assert_illegal_no_strb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (acc_strb_o == '0 && acc_we_o));
  assert_beat2_stride_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_beat_o |-> (acc_addr_o == $past(acc_addr_o) + XLEN'(NB) && acc_strb_o != '0 || !acc_we_o));
  assert_wb_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_beat_o |-> !wb_en_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !acc_beat_o) |-> (!acc_valid_o && !wb_en_o));
endmodule

// File: tb/sim_ldst_addr_unit.sv
module sim_ldst_addr_unit;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i, req_ready_o, sub_i, store_i, pair_i;
  logic [31:0] base_i, wdata_i, wdata2_i, acc_addr_o, acc_wdata_o, mem_rdata_i, ld_data_o, wb_data_o;
  logic [11:0] off_i;
  logic [1:0]  mode_i;
  logic [2:0]  size_i;
  logic acc_valid_o, acc_beat_o, acc_we_o, wb_en_o, illegal_o;
  logic [3:0] acc_strb_o;
  logic [31:0] mem [0:15];
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  ldst_addr_unit u0 (.*);

  assign mem_rdata_i = mem[acc_addr_o[5:2]];
  always @(posedge clk_i)
    if (acc_valid_o && acc_we_o)
      for (int b = 0; b < 4; b++)
        if (acc_strb_o[b]) mem[acc_addr_o[5:2]][b*8 +: 8] <= acc_wdata_o[b*8 +: 8];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] m, logic [2:0] s, logic st, logic pr,
                       logic [31:0] b, logic [11:0] o, logic sb,
                       logic [31:0] wd, logic [31:0] wd2);
    @(negedge clk_i);
    req_valid_i = 1'b1; mode_i = m; size_i = s; store_i = st; pair_i = pr;
    base_i = b; off_i = o; sub_i = sb; wdata_i = wd; wdata2_i = wd2;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_valid_i = 1'b0; pair_i = 1'b0; store_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 ready in reset", 32'(req_ready_o), 1);
    chk("R11 no access in reset", 32'(acc_valid_o), 0);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R11 ready after reset", 32'(req_ready_o), 1);
    chk("R11 idle no wb", 32'(wb_en_o), 0);
  endtask

  task automatic t_modes();
    drive(2'd0, 3'd4, 0, 0, 32'h0000_1000, 12'h024, 0, 0, 0);
    chk("R1 offset addr", acc_addr_o, 32'h0000_1024);
    chk("R1 offset no wb", 32'(wb_en_o), 0);
    chk("R11 single keeps ready", 32'(req_ready_o), 1);
    drive(2'd3, 3'd4, 0, 0, 32'h0000_1000, 12'h010, 1, 0, 0);
    chk("R1 reserved as offset", acc_addr_o, 32'h0000_0FF0);
    chk("R1 reserved no wb", 32'(wb_en_o), 0);
    drive(2'd1, 3'd4, 0, 0, 32'h0000_2000, 12'hFFF, 0, 0, 0);
    chk("R2 pre addr", acc_addr_o, 32'h0000_2FFF);
    chk("R2 pre wb en", 32'(wb_en_o), 1);
    chk("R2 pre wb data", wb_data_o, 32'h0000_2FFF);
    drive(2'd2, 3'd4, 0, 0, 32'h0000_0008, 12'h00C, 1, 0, 0);
    chk("R3 post addr", acc_addr_o, 32'h0000_0008);
    chk("R3 post wb en", 32'(wb_en_o), 1);
    chk("R3 post wb wraps", wb_data_o, 32'hFFFF_FFFC);
    drive(2'd0, 3'd4, 0, 0, 32'h0000_0040, 12'h000, 1, 0, 0);
    chk("R4 zero offset", acc_addr_o, 32'h0000_0040);
    drive(2'd0, 3'd4, 0, 0, 32'h0000_0040, 12'hFFF, 1, 0, 0);
    chk("R4 subtract max", acc_addr_o, 32'hFFFF_F041);
    idle();
    chk("R11 idle no access", 32'(acc_valid_o), 0);
  endtask

  task automatic t_loads();
    mem[1] = 32'h80F1_7F82;
    drive(2'd0, 3'd0, 0, 0, 32'h4, 12'd0, 0, 0, 0);
    chk("R5 UB lane0", ld_data_o, 32'h0000_0082);
    drive(2'd0, 3'd1, 0, 0, 32'h4, 12'd0, 0, 0, 0);
    chk("R5 SB lane0 neg", ld_data_o, 32'hFFFF_FF82);
    drive(2'd0, 3'd1, 0, 0, 32'h4, 12'd1, 0, 0, 0);
    chk("R5 SB lane1 pos", ld_data_o, 32'h0000_007F);
    drive(2'd0, 3'd0, 0, 0, 32'h4, 12'd3, 0, 0, 0);
    chk("R5 UB lane3", ld_data_o, 32'h0000_0080);
    drive(2'd0, 3'd3, 0, 0, 32'h4, 12'd2, 0, 0, 0);
    chk("R6 SH upper", ld_data_o, 32'hFFFF_80F1);
    drive(2'd0, 3'd2, 0, 0, 32'h4, 12'd2, 0, 0, 0);
    chk("R6 UH upper", ld_data_o, 32'h0000_80F1);
    drive(2'd0, 3'd3, 0, 0, 32'h4, 12'd0, 0, 0, 0);
    chk("R6 SH lower", ld_data_o, 32'h0000_7F82);
    drive(2'd0, 3'd4, 0, 0, 32'h4, 12'd0, 0, 0, 0);
    chk("R6 word", ld_data_o, 32'h80F1_7F82);
    chk("R7 load no strobes", 32'(acc_strb_o), 0);
    idle();
  endtask

  task automatic t_stores();
    mem[2] = 32'h0;
    drive(2'd0, 3'd0, 1, 0, 32'h8, 12'd2, 0, 32'h1234_56AB, 0);
    chk("R7 byte strb", 32'(acc_strb_o), 32'h4);
    chk("R7 byte data", acc_wdata_o, 32'hABAB_ABAB);
    drive(2'd0, 3'd2, 1, 0, 32'h8, 12'd2, 0, 32'h1234_CAFE, 0);
    chk("R7 half hi strb", 32'(acc_strb_o), 32'hC);
    chk("R7 half data", acc_wdata_o, 32'hCAFE_CAFE);
    drive(2'd0, 3'd2, 1, 0, 32'h8, 12'd0, 0, 32'h0000_BEEF, 0);
    chk("R7 half lo strb", 32'(acc_strb_o), 32'h3);
    drive(2'd0, 3'd4, 1, 0, 32'h8, 12'd4, 0, 32'h1111_2222, 0);
    chk("R7 word strb", 32'(acc_strb_o), 32'hF);
    idle();
    chk("R7 merged memory", mem[2], 32'hCAFE_BEEF);
    drive(2'd0, 3'd1, 1, 0, 32'h8, 12'd1, 0, 32'hFFFF_FFFF, 0);
    chk("R8 SB store illegal", 32'(illegal_o), 1);
    chk("R8 SB store no strb", 32'(acc_strb_o), 0);
    drive(2'd0, 3'd3, 1, 0, 32'h8, 12'd0, 0, 32'hFFFF_FFFF, 0);
    chk("R8 SH store illegal", 32'(illegal_o), 1);
    idle();
    chk("R8 memory untouched", mem[2], 32'hCAFE_BEEF);
    drive(2'd0, 3'd1, 0, 0, 32'h8, 12'd0, 0, 0, 0);
    chk("R8 signed load legal", 32'(illegal_o), 0);
    idle();
  endtask

  task automatic t_pair_store();
    mem[4] = 0; mem[5] = 0;
    drive(2'd1, 3'd4, 1, 1, 32'h8, 12'd8, 0, 32'hAAAA_0001, 32'hBBBB_0002);
    chk("R9 beat0 addr", acc_addr_o, 32'h10);
    chk("R9 beat0 index", 32'(acc_beat_o), 0);
    chk("R10 wb on accept", 32'(wb_en_o), 1);
    chk("R2 pair wb data", wb_data_o, 32'h10);
    @(negedge clk_i); #1;
    chk("R9 beat1 index", 32'(acc_beat_o), 1);
    chk("R9 beat1 addr", acc_addr_o, 32'h14);
    chk("R10 ready low beat1", 32'(req_ready_o), 0);
    chk("R10 no wb beat1", 32'(wb_en_o), 0);
    chk("R9 beat1 data", acc_wdata_o, 32'hBBBB_0002);
    idle();
    chk("R10 ready back", 32'(req_ready_o), 1);
    chk("R9 first word", mem[4], 32'hAAAA_0001);
    chk("R9 second word", mem[5], 32'hBBBB_0002);
  endtask

  task automatic t_pair_load();
    mem[6] = 32'h8000_0001; mem[7] = 32'hFFFF_0080;
    drive(2'd2, 3'd0, 0, 1, 32'h18, 12'd8, 0, 0, 0);
    chk("R9 post pair beat0", acc_addr_o, 32'h18);
    chk("R9 pair word beat0", ld_data_o, 32'h8000_0001);
    chk("R3 pair post wb", wb_data_o, 32'h20);
    @(negedge clk_i); #1;
    chk("R9 post pair beat1", acc_addr_o, 32'h1C);
    chk("R9 pair word beat1", ld_data_o, 32'hFFFF_0080);
    idle();
  endtask

  initial begin
    req_valid_i = 0; sub_i = 0; store_i = 0; pair_i = 0; base_i = 0; off_i = 0;
    mode_i = 0; size_i = 0; wdata_i = 0; wdata2_i = 0;
    for (int i = 0; i < 16; i++) mem[i] = 0;
    #1;
    t_reset();
    t_modes();
    t_loads();
    t_stores();
    t_pair_store();
    t_pair_load();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule